// File: doc/BRIEF.md
# Periodic / Nonperiodic DMA Time-Slice Arbiter

This block decides, cycle by cycle, whether a shared DMA engine works for periodic IN endpoints or for nonperiodic endpoints. A frame-start pulse opens a periodic window at the start of each (micro)frame. The window's length is a fraction of the frame length, given in clock cycles, and a 2-bit interval code selects the fraction. Inside the window, pending periodic requests win. Outside it, and whenever no periodic endpoint is marked active, nonperiodic requests are served.

The interval code is a configuration value. It is taken in only when a load strobe arrives while the arbiter is idle, and it takes effect at the next frame start. The reserved code falls back to the shortest window and sets a sticky error flag. Grants are registered and one-hot. Within each class, the request with the lowest index is chosen.

Top module: `dma_slice_arb`

## Requirements
- R1: The window length W in clocks, for frame length L, is floor(L/4) when the latched code is 2'b00, floor(L/2) when it is 2'b01, and floor(L/2)+floor(L/4) when it is 2'b10. The length is taken at the clock edge that samples `sof_i` high. `win_open_o` then reads 1 for exactly W consecutive cycles, starting in the cycle after that edge.
- R2: A load with code 2'b11 makes later windows use the floor(L/4) length. It also sets `cfg_err_o`, which stays at 1 until reset.
- R3: While reset is high and in the first cycle after it, all grants, `win_open_o` and `cfg_err_o` are 0. The latched code after reset is 2'b10.
- R4: `cfg_code_i` is latched only at an edge where `cfg_load_i` is 1 and the block is idle. Idle means that no bit of `per_req_i` or `np_req_i` is set and no grant output is set. A load at any other time is ignored. A latched code applies from the next frame start.
- R5: A periodic grant is issued when three conditions hold in the sampled cycle: `win_open_o` is 1, some bit of `per_active_i` is set, and some bit of `per_req_i` is set. The grant goes to the lowest set bit of `per_req_i` (bit i of `per_gnt_o` serves bit i), and no nonperiodic grant is given in that case.
- R6: When no periodic grant is issued and some bit of `np_req_i` is set, `np_gnt_o` grants the lowest set bit of `np_req_i`, even inside an open window.
- R7: Once the window has closed, periodic requests are not granted until the next frame start.
- R8: When every bit of `per_active_i` is 0, no periodic grant is issued, whatever the window state or the code.
- R9: Grants appear one cycle after the request cycle that caused them. Across `per_gnt_o` and `np_gnt_o` together, at most one bit is set.
- R10: In the cycle after `sof_i` is sampled high, both grant vectors are 0. A frame start reloads the full window even when the previous window is still open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Frame-start pulse |
| frame_len_i | input | LEN_W | Frame length in clock cycles |
| cfg_load_i | input | 1 | Strobe to latch the interval code |
| cfg_code_i | input | 2 | Interval code (00 quarter, 01 half, 10 three quarters, 11 reserved) |
| per_active_i | input | NPER | Periodic endpoint active flags |
| per_req_i | input | NPER | Periodic service requests |
| np_req_i | input | NNP | Nonperiodic service requests |
| per_gnt_o | output | NPER | One-hot periodic grant |
| np_gnt_o | output | NNP | One-hot nonperiodic grant |
| win_open_o | output | 1 | Periodic window is open |
| cfg_err_o | output | 1 | Sticky flag: reserved code was loaded |

## Verification
Two situations are hard to reach from the ports. The first is the exact last cycle of a long window, where the grant must hand over from periodic to nonperiodic service; the bench reaches it by running 60000-clock frames to completion while a cycle-accurate model tracks the remaining window. The second is a load strobe that arrives while traffic is still pending, which must be ignored; the bench issues that strobe with requests held high and then measures the length of the next window, so the effect shows at the ports. Back-to-back frame starts and periodic-active flags that drop mid-window are also driven, so the re-arm and fallback paths are exercised.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic [1:0] {
    IVL_QTR  = 2'b00,
    IVL_HALF = 2'b01,
    IVL_3QTR = 2'b10,
    IVL_RSVD = 2'b11
  } ivl_e;

  localparam ivl_e IVL_RESET = IVL_3QTR;
endpackage

// File: rtl/dsa_cfg.sv
module dsa_cfg
  import dsa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [1:0] code_i,
  input  logic       idle_i,
  output ivl_e       code_o,
  output logic       err_o
);
  ivl_e code_q;
  logic err_q;
  logic take;

  assign take = load_i && idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= IVL_RESET;
      err_q  <= 1'b0;
    end else if (take) begin
      if (code_i == 2'b11) begin
        code_q <= IVL_QTR;
        err_q  <= 1'b1;
      end else begin
        code_q <= ivl_e'(code_i);
      end
    end
  end

  assign code_o = code_q;
  assign err_o  = err_q;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(load_i && idle_i) |=> $stable(code_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R2
  AST_NO_RSVD_KEPT: assert property (@(posedge clk) disable iff (rst)
    code_q != IVL_RSVD); // R2
endmodule

// File: rtl/dsa_window.sv
module dsa_window
  import dsa_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic [LEN_W-1:0] len_i,
  input  ivl_e             code_i,
  output logic             open_o
);
  logic [LEN_W-1:0] quarter, half, wlen;
  logic [LEN_W-1:0] rem_q;
  logic             open_q;

  assign quarter = len_i >> 2;
  assign half    = len_i >> 1;

  always_comb begin
    unique case (code_i)
      IVL_HALF: wlen = half;
      IVL_3QTR: wlen = half + quarter;
      default:  wlen = quarter;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      open_q <= 1'b0;
    end else if (sof_i) begin
      rem_q  <= wlen;
      open_q <= (wlen != '0);
    end else if (rem_q != '0) begin
      rem_q  <= rem_q - 1'b1;
      open_q <= (rem_q > 1);
    end
  end

  assign open_o = open_q;

  AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (!sof_i && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1)); // R1
  AST_WIN_STAYS_SHUT: assert property (@(posedge clk) disable iff (rst)
    (!sof_i && rem_q == '0) |=> (rem_q == '0)); // R7
  AST_OPEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    open_q == (rem_q != '0)); // R1
endmodule

// File: rtl/dsa_pick.sv
module dsa_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign seen[i] = seen[i-1] | req_i[i-1];
  end

  assign gnt_o = req_i & ~seen;

  always_comb begin
    AST_PICK_ONEHOT: assert ($onehot0(gnt_o)); // R9
  end
endmodule

// File: rtl/dma_slice_arb.sv
module dma_slice_arb
  import dsa_pkg::*;
#(
  parameter int NPER  = 4,
  parameter int NNP   = 4,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             cfg_load_i,
  input  logic [1:0]       cfg_code_i,
  input  logic [NPER-1:0]  per_active_i,
  input  logic [NPER-1:0]  per_req_i,
  input  logic [NNP-1:0]   np_req_i,
  output logic [NPER-1:0]  per_gnt_o,
  output logic [NNP-1:0]   np_gnt_o,
  output logic             win_open_o,
  output logic             cfg_err_o
);
  ivl_e            code;
  logic            win_open;
  logic            idle;
  logic            per_ok;
  logic [NPER-1:0] per_pick;
  logic [NNP-1:0]  np_pick;
  logic [NPER-1:0] per_gnt_q;
  logic [NNP-1:0]  np_gnt_q;

  assign idle = ~|per_req_i & ~|np_req_i & ~|per_gnt_q & ~|np_gnt_q;

  dsa_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load_i (cfg_load_i),
    .code_i (cfg_code_i),
    .idle_i (idle),
    .code_o (code),
    .err_o  (cfg_err_o)
  );

  dsa_window #(.LEN_W(LEN_W)) u_win (
    .clk    (clk),
    .rst    (rst),
    .sof_i  (sof_i),
    .len_i  (frame_len_i),
    .code_i (code),
    .open_o (win_open)
  );

  dsa_pick #(.N(NPER)) u_pick_per (
    .req_i (per_req_i),
    .gnt_o (per_pick)
  );

  dsa_pick #(.N(NNP)) u_pick_np (
    .req_i (np_req_i),
    .gnt_o (np_pick)
  );

  assign per_ok = !sof_i && win_open && (|per_active_i) && (|per_req_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_gnt_q <= '0;
      np_gnt_q  <= '0;
    end else begin
      per_gnt_q <= per_ok ? per_pick : '0;
      np_gnt_q  <= (!sof_i && !per_ok) ? np_pick : '0;
    end
  end

  assign per_gnt_o  = per_gnt_q;
  assign np_gnt_o   = np_gnt_q;
  assign win_open_o = win_open;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({per_gnt_o, np_gnt_o})); // R9
  AST_SOF_QUIET: assert property (@(posedge clk) disable iff (rst)
    sof_i |=> (per_gnt_o == '0 && np_gnt_o == '0)); // R10
  AST_PER_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    win_open_o == 1'b0 && !sof_i |=> per_gnt_o == '0); // R7
  AST_PER_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    per_active_i == '0 |=> per_gnt_o == '0); // R8
  AST_PER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!sof_i && win_open_o && |per_active_i && |per_req_i) |=> np_gnt_o == '0); // R5
  AST_NP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    |np_gnt_o |-> (np_gnt_o & ~$past(np_req_i)) == '0); // R6
endmodule

// File: tb/dma_slice_arb_bench.sv
`timescale 1ns/1ps
module dma_slice_arb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sof_i = 1'b0;
  logic [15:0] frame_len_i = 16'd7500;
  logic        cfg_load_i = 1'b0;
  logic [1:0]  cfg_code_i = 2'b00;
  logic [3:0]  per_active_i = 4'd0;
  logic [3:0]  per_req_i = 4'd0;
  logic [3:0]  np_req_i = 4'd0;
  logic [3:0]  per_gnt_o;
  logic [3:0]  np_gnt_o;
  logic        win_open_o;
  logic        cfg_err_o;

  int n_chk = 0;
  int n_fail = 0;
  int win_cnt = 0;
  int m_rem = 0;
  logic m_win = 1'b0;
  logic [3:0] m_per = 4'd0, m_np = 4'd0;
  logic [1:0] m_code = 2'b10;
  logic m_err = 1'b0;

  always #10 clk = ~clk;

  dma_slice_arb u_dma_slice_arb (
    .clk          (clk),
    .rst          (rst),
    .sof_i        (sof_i),
    .frame_len_i  (frame_len_i),
    .cfg_load_i   (cfg_load_i),
    .cfg_code_i   (cfg_code_i),
    .per_active_i (per_active_i),
    .per_req_i    (per_req_i),
    .np_req_i     (np_req_i),
    .per_gnt_o    (per_gnt_o),
    .np_gnt_o     (np_gnt_o),
    .win_open_o   (win_open_o),
    .cfg_err_o    (cfg_err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wlen_f(input int len, input logic [1:0] c);
    case (c)
      2'b01:   return len / 2;
      2'b10:   return len / 2 + len / 4;
      default: return len / 4;
    endcase
  endfunction

  // One clock: model update from the held inputs, then compare after the edge.
  task automatic step(input logic sof);
    logic idle, pok;
    logic [3:0] pe, ne;
    logic [1:0] code_old;
    sof_i = sof;
    idle = (per_req_i == 0) && (np_req_i == 0) && (m_per == 0) && (m_np == 0);
    code_old = m_code;
    pok = !sof && m_win && (per_active_i != 0) && (per_req_i != 0);
    pe = pok ? (per_req_i & (~per_req_i + 4'd1)) : 4'd0;
    ne = (!sof && !pok) ? (np_req_i & (~np_req_i + 4'd1)) : 4'd0;
    if (cfg_load_i && idle) begin
      m_code = (cfg_code_i == 2'b11) ? 2'b00 : cfg_code_i;
      if (cfg_code_i == 2'b11) m_err = 1'b1;
    end
    if (sof) m_rem = wlen_f(int'(frame_len_i), code_old);
    else if (m_rem > 0) m_rem--;
    m_win = (m_rem != 0);
    m_per = pe;
    m_np = ne;
    @(posedge clk);
    @(negedge clk);
    sof_i = 1'b0;
    cfg_load_i = 1'b0;
    if (sof) win_cnt = 0;
    if (win_open_o) win_cnt++;
    chk(per_gnt_o === m_per, "R5 R7 R8 R9 periodic grant", int'(per_gnt_o), int'(m_per));
    chk(np_gnt_o === m_np, "R6 R9 nonperiodic grant", int'(np_gnt_o), int'(m_np));
    chk(win_open_o === m_win, "R1 window flag", int'(win_open_o), int'(m_win));
  endtask

  task automatic run(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      per_req_i = (((i + seed) % 7) < 3) ? 4'd0 : 4'((i + seed) >> 2);
      np_req_i  = 4'((i * 5 + seed) >> 1);
      step(1'b0);
    end
  endtask

  task automatic quiesce();
    per_req_i = 4'd0;
    np_req_i = 4'd0;
    step(1'b0);
    step(1'b0);
  endtask

  task automatic load_code(input logic [1:0] c);
    quiesce();
    cfg_code_i = c;
    cfg_load_i = 1'b1;
    step(1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(per_gnt_o == 0 && np_gnt_o == 0, "R3 grants in reset", int'({per_gnt_o, np_gnt_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(win_open_o == 1'b0, "R3 window after reset", int'(win_open_o), 0);
    chk(cfg_err_o == 1'b0, "R3 error after reset", int'(cfg_err_o), 0);
    per_active_i = 4'b1111;
    frame_len_i = 16'd7500;
    step(1'b1);
    run(5700, 1);
    chk(win_cnt == 5625, "R3 default code gives 75% window", win_cnt, 5625);
  endtask

  task automatic t_codes_small();
    int expv[4] = '{1875, 3750, 5625, 1875};
    frame_len_i = 16'd7500;
    for (int c = 0; c < 4; c++) begin
      load_code(2'(c));
      step(1'b1);
      run(expv[c] + 25, c + 3);
      chk(win_cnt == expv[c], "R1 R2 window length per code at 7500", win_cnt, expv[c]);
    end
    chk(cfg_err_o == 1'b1, "R2 reserved code sets error", int'(cfg_err_o), 1);
  endtask

  task automatic t_codes_big();
    frame_len_i = 16'd60000;
    load_code(2'b01);
    step(1'b1);
    run(30010, 11);
    chk(win_cnt == 30000, "R1 half window at 60000", win_cnt, 30000);
    load_code(2'b10);
    step(1'b1);
    run(45010, 12);
    chk(win_cnt == 45000, "R1 R7 three-quarter window at 60000", win_cnt, 45000);
    chk(cfg_err_o == 1'b1, "R2 error stays set", int'(cfg_err_o), 1);
  endtask

  task automatic t_busy_load();
    frame_len_i = 16'd7500;
    per_req_i = 4'b0010;
    np_req_i = 4'b0001;
    cfg_code_i = 2'b00;
    cfg_load_i = 1'b1;
    step(1'b0);
    step(1'b1);
    run(5700, 21);
    chk(win_cnt == 5625, "R4 load while busy ignored", win_cnt, 5625);
  endtask

  task automatic t_active_toggle();
    int pg = 0;
    frame_len_i = 16'd7500;
    per_active_i = 4'b1111;
    step(1'b1);
    run(1000, 31);
    per_active_i = 4'b0000;
    for (int i = 0; i < 500; i++) begin
      per_req_i = 4'b1100;
      np_req_i = 4'b0110;
      step(1'b0);
      if (per_gnt_o != 0) pg++;
    end
    chk(pg == 0, "R8 no periodic grant while none active", pg, 0);
    chk(np_gnt_o == 4'b0010, "R6 R8 lowest nonperiodic served", int'(np_gnt_o), 2);
    per_active_i = 4'b0100;
    per_req_i = 4'b1010;
    step(1'b0);
    chk(per_gnt_o == 4'b0010, "R5 lowest periodic wins in window", int'(per_gnt_o), 2);
    chk(np_gnt_o == 4'b0000, "R5 nonperiodic held off", int'(np_gnt_o), 0);
    per_req_i = 4'b0000;
    step(1'b0);
    chk(np_gnt_o == 4'b0010, "R6 work-conserving in window", int'(np_gnt_o), 2);
    run(4200, 32);
    per_req_i = 4'b1000;
    np_req_i = 4'b0100;
    step(1'b0);
    chk(per_gnt_o == 0 && np_gnt_o == 4'b0100, "R7 after window nonperiodic only",
        int'({per_gnt_o, np_gnt_o}), 4);
  endtask

  task automatic t_back2back();
    frame_len_i = 16'd7500;
    per_active_i = 4'b1111;
    per_req_i = 4'b0001;
    np_req_i = 4'b0001;
    for (int k = 0; k < 3; k++) begin
      step(1'b1);
      chk(per_gnt_o == 0 && np_gnt_o == 0, "R10 no grant after frame start",
          int'({per_gnt_o, np_gnt_o}), 0);
    end
    run(2000, 41);
    step(1'b1);
    run(5700, 42);
    chk(win_cnt == 5625, "R10 frame start re-arms full window", win_cnt, 5625);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_codes_small();
    t_codes_big();
    t_busy_load();
    t_active_toggle();
    t_back2back();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule